// File: doc/BRIEF.md
# Convert-Start Sequencing Controller

This block runs one conversion of a successive-approximation converter from an asynchronous, edge-driven convert-start pin. Between conversions the analog core stays powered off. A rising edge on the pin powers the core up. The length of the high pulse serves as the power-up settling window. A falling edge switches the track-and-hold to hold and sends a start strobe to the bit-trial engine. The core is released back to shutdown once a minimum conversion time has passed and the engine has signalled completion.

All timing is counted in reference-clock cycles set by two parameters. With a 125 MHz clock, the defaults correspond to a 1 µs power-up window and a 2 µs conversion. When the high pulse is shorter than the power-up window, the block still completes the conversion. In that case it reports the result as invalid rather than valid.

Top module: `convStartSeq`

## Requirements
- R1: After reset, powerUp, holdMode, busy, startPulse, resultValid and resultInvalid are all low.
- R2: The pin passes through a two-flop synchroniser. powerUp rises at the third rising clock edge after the pin goes high while the block is idle.
- R3: Hold and conversion start on the pin's falling edge, with the same three-edge latency. busy and holdMode rise together, and startPulse is high for exactly one clock cycle, the first cycle of busy.
- R4: When the engine reports done early, busy stays high for exactly CONV_CYCLES clocks. powerUp falls on the same edge as busy.
- R5: A high pulse lasting PWRUP_CYCLES clocks or more produces exactly one one-clock resultValid pulse at the end of the conversion, and no resultInvalid.
- R6: A high pulse shorter than PWRUP_CYCLES clocks produces one resultInvalid pulse at the end of the conversion, and no resultValid.
- R7: If engineDone has not arrived once CONV_CYCLES have passed, busy stays high. The conversion ends on the edge at which engineDone is sampled high.
- R8: Edges on the pin while busy is high are ignored. The conversion keeps its length, and only one start strobe and one result pulse are produced.
- R9: engineDone asserted outside a conversion (during power-up) does not count toward ending the next conversion.
- R10: The power-up measurement saturates. A very long high pulse (longer than the counter's range) is still reported valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convStartIn | input | 1 | Asynchronous convert-start pin |
| engineDone | input | 1 | Completion from the bit-trial engine |
| powerUp | output | 1 | Analog core power enable |
| holdMode | output | 1 | Track-and-hold in hold |
| startPulse | output | 1 | One-cycle start strobe to the engine |
| busy | output | 1 | Conversion in progress |
| resultValid | output | 1 | One-cycle pulse: result is good |
| resultInvalid | output | 1 | One-cycle pulse: power-up window was too short |

## Verification
The bench builds the block with PWRUP_CYCLES = 8 and CONV_CYCLES = 12. These small values make the pulse-width boundary (7 versus 8 clocks) and the exact busy length cheap to reach. Because the power counter is then only four bits wide, a 37-clock pulse is enough to expose any wraparound. Late, stray and early engine completions, as well as re-triggering during a conversion, all fit in short directed runs.

// File: rtl/csPkg.sv
package csPkg;

  typedef enum logic [1:0] {
    ST_SHUT = 2'd0,
    ST_PWR  = 2'd1,
    ST_CONV = 2'd2
  } csState_e;

  typedef struct packed {
    logic pwrClr;
    logic pwrInc;
    logic convClr;
    logic convInc;
    logic shortCapture;
  } csStrobes_t;

endpackage

// File: rtl/csSync.sv
module csSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[0] <= 1'b0;
        else       chain[0] <= asyncIn;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[i] <= 1'b0;
        else       chain[i] <= chain[i-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/csDatapath.sv
module csDatapath import csPkg::*; #(
  parameter int PWRUP_CYCLES = 125,
  parameter int CONV_CYCLES  = 250
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       engineDone,
  input  csStrobes_t strobes,
  output logic       pwrShort,
  output logic       convDue,
  output logic       shortLatched
);
  localparam int PW_W = $clog2(PWRUP_CYCLES + 1);
  localparam int CV_W = $clog2(CONV_CYCLES + 1);
  localparam logic [PW_W-1:0] PW_MAX = PW_W'(PWRUP_CYCLES);
  localparam logic [CV_W-1:0] CV_MAX = CV_W'(CONV_CYCLES);

  logic [PW_W-1:0] pwrCnt;
  logic [CV_W-1:0] convCnt;
  logic            doneSeen;

  // power window: starts at 1 on entry, saturates at the threshold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                pwrCnt <= '0;
    else if (strobes.pwrClr)                  pwrCnt <= PW_W'(1);
    else if (strobes.pwrInc && pwrCnt != PW_MAX) pwrCnt <= pwrCnt + PW_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convCnt  <= '0;
      doneSeen <= 1'b0;
    end else if (strobes.convClr) begin
      convCnt  <= CV_W'(1);
      doneSeen <= 1'b0;
    end else if (strobes.convInc) begin
      if (convCnt != CV_MAX) convCnt <= convCnt + CV_W'(1);
      if (engineDone)        doneSeen <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     shortLatched <= 1'b0;
    else if (strobes.shortCapture) shortLatched <= pwrShort;
  end

  assign pwrShort = (pwrCnt < PW_MAX);
  assign convDue  = (convCnt >= CV_MAX) && (doneSeen || engineDone);

  // R10: power window counter never runs past its threshold
  p_pwr_saturate_r10: assert property (@(posedge clk) disable iff (!rstN)
    pwrCnt <= PW_MAX);

  // R4: conversion counter never runs past its limit
  p_conv_saturate_r4: assert property (@(posedge clk) disable iff (!rstN)
    convCnt <= CV_MAX);
endmodule

// File: rtl/csControl.sv
module csControl import csPkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  input  logic       pwrShort,
  input  logic       convDue,
  input  logic       shortLatched,
  output csStrobes_t strobes,
  output csState_e   state,
  output logic       startPulse,
  output logic       resultValid,
  output logic       resultInvalid
);
  logic     syncPrev, riseEdge, fallEdge;
  csState_e nextState;
  logic     startNext, validNext, invalidNext;

  assign riseEdge = syncIn & ~syncPrev;
  assign fallEdge = ~syncIn & syncPrev;

  always_comb begin
    nextState   = state;
    strobes     = '0;
    startNext   = 1'b0;
    validNext   = 1'b0;
    invalidNext = 1'b0;
    unique case (state)
      ST_SHUT: if (riseEdge) begin
        nextState      = ST_PWR;
        strobes.pwrClr = 1'b1;
      end
      ST_PWR: begin
        strobes.pwrInc = 1'b1;
        if (fallEdge) begin
          nextState            = ST_CONV;
          strobes.convClr      = 1'b1;
          strobes.shortCapture = 1'b1;
          startNext            = 1'b1;
        end
      end
      ST_CONV: begin
        strobes.convInc = 1'b1;
        if (convDue) begin
          nextState   = ST_SHUT;
          validNext   = ~shortLatched;
          invalidNext = shortLatched;
        end
      end
      default: nextState = ST_SHUT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev      <= 1'b0;
      state         <= ST_SHUT;
      startPulse    <= 1'b0;
      resultValid   <= 1'b0;
      resultInvalid <= 1'b0;
    end else begin
      syncPrev      <= syncIn;
      state         <= nextState;
      startPulse    <= startNext;
      resultValid   <= validNext;
      resultInvalid <= invalidNext;
    end
  end

  // R3: the start strobe only appears inside a conversion
  p_start_in_conv_r3: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> (state == ST_CONV));

  // R3: entering a conversion always comes with the start strobe
  p_conv_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_CONV) |-> startPulse);

  // R4: leaving a conversion always reports exactly one result flag
  p_end_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(state == ST_CONV) |-> (resultValid ^ resultInvalid));

  // R5: valid lasts one clock
  p_valid_one_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R6: valid and invalid are never raised together
  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(resultValid && resultInvalid));

  // R4: a result is reported only with the core back in shutdown
  p_result_shut_r4: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid || resultInvalid) |-> (state == ST_SHUT));
endmodule

// File: rtl/convStartSeq.sv
module convStartSeq import csPkg::*; #(
  parameter int PWRUP_CYCLES = 125,
  parameter int CONV_CYCLES  = 250,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic convStartIn,
  input  logic engineDone,
  output logic powerUp,
  output logic holdMode,
  output logic startPulse,
  output logic busy,
  output logic resultValid,
  output logic resultInvalid
);
  logic       syncIn, pwrShort, convDue, shortLatched;
  csStrobes_t strobes;
  csState_e   state;

  csSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(convStartIn), .syncOut(syncIn)
  );

  csControl uCtrl (
    .clk(clk), .rstN(rstN), .syncIn(syncIn),
    .pwrShort(pwrShort), .convDue(convDue), .shortLatched(shortLatched),
    .strobes(strobes), .state(state), .startPulse(startPulse),
    .resultValid(resultValid), .resultInvalid(resultInvalid)
  );

  csDatapath #(.PWRUP_CYCLES(PWRUP_CYCLES), .CONV_CYCLES(CONV_CYCLES)) uDp (
    .clk(clk), .rstN(rstN), .engineDone(engineDone), .strobes(strobes),
    .pwrShort(pwrShort), .convDue(convDue), .shortLatched(shortLatched)
  );

  assign powerUp  = (state != ST_SHUT);
  assign holdMode = (state == ST_CONV);
  assign busy     = (state == ST_CONV);
endmodule

// File: tb/tb_convStartSeq.sv
module tb_convStartSeq;
  localparam int PW = 8;
  localparam int CV = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convStartIn = 1'b0;
  logic autoDone = 1'b1;
  logic manualDone = 1'b0;
  logic engineDone;
  logic powerUp, holdMode, startPulse, busy, resultValid, resultInvalid;

  int checks = 0, failures = 0;
  int busyCnt = 0, validCnt = 0, invalidCnt = 0, startCnt = 0;

  always #4 clk = ~clk;

  assign engineDone = autoDone ? busy : manualDone;

  convStartSeq #(.PWRUP_CYCLES(PW), .CONV_CYCLES(CV)) dut (
    .clk(clk), .rstN(rstN), .convStartIn(convStartIn), .engineDone(engineDone),
    .powerUp(powerUp), .holdMode(holdMode), .startPulse(startPulse),
    .busy(busy), .resultValid(resultValid), .resultInvalid(resultInvalid)
  );

  always @(posedge clk) begin
    #2;
    busyCnt    += int'(busy);
    validCnt   += int'(resultValid);
    invalidCnt += int'(resultInvalid);
    startCnt   += int'(startPulse);
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clrCounts();
    @(negedge clk);
    busyCnt = 0; validCnt = 0; invalidCnt = 0; startCnt = 0;
  endtask

  task automatic pulse(input int highClocks);
    @(negedge clk) convStartIn = 1'b1;
    repeat (highClocks) @(negedge clk);
    convStartIn = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 powerUp", powerUp, 0);
    chk("R1 holdMode", holdMode, 0);
    chk("R1 busy", busy, 0);
    chk("R1 startPulse", startPulse, 0);
    chk("R1 flags", resultValid | resultInvalid, 0);
  endtask

  task automatic tNominal();
    clrCounts();
    autoDone = 1'b1;
    convStartIn = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 powerUp early", powerUp, 0);
    @(negedge clk);
    chk("R2 powerUp on", powerUp, 1);
    repeat (PW + 2 - 3) @(negedge clk);
    convStartIn = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 busy early", busy, 0);
    @(negedge clk);
    chk("R3 busy on", busy, 1);
    chk("R3 holdMode on", holdMode, 1);
    chk("R3 startPulse on", startPulse, 1);
    @(negedge clk);
    chk("R3 startPulse one cycle", startPulse, 0);
    repeat (CV + 4) @(negedge clk);
    chk("R4 busy length", busyCnt, CV);
    chk("R4 powerUp off", powerUp, 0);
    chk("R5 valid count", validCnt, 1);
    chk("R5 invalid count", invalidCnt, 0);
  endtask

  task automatic runAndCount(input int highClocks, output int v, output int iv);
    clrCounts();
    autoDone = 1'b1;
    pulse(highClocks);
    repeat (CV + 8) @(negedge clk);
    v = validCnt;
    iv = invalidCnt;
  endtask

  task automatic tBoundary();
    int v, iv;
    runAndCount(PW, v, iv);
    chk("R5 exact width valid", v, 1);
    chk("R5 exact width no invalid", iv, 0);
    runAndCount(PW - 1, v, iv);
    chk("R6 short by one invalid", iv, 1);
    chk("R6 short by one no valid", v, 0);
    runAndCount(1, v, iv);
    chk("R6 one-clock pulse invalid", iv, 1);
    chk("R6 one-clock pulse no valid", v, 0);
  endtask

  task automatic tLateDone();
    clrCounts();
    autoDone = 1'b0;
    manualDone = 1'b0;
    pulse(PW + 2);
    repeat (3 + CV + 4) @(negedge clk);
    chk("R7 busy waits for done", busy, 1);
    chk("R7 no result yet", validCnt, 0);
    manualDone = 1'b1;
    @(negedge clk);
    manualDone = 1'b0;
    chk("R7 busy off after done", busy, 0);
    chk("R7 valid on done edge", resultValid, 1);
    @(negedge clk);
    chk("R7 valid one cycle", resultValid, 0);
    autoDone = 1'b1;
  endtask

  task automatic tRefire();
    clrCounts();
    autoDone = 1'b1;
    pulse(PW + 2);
    repeat (5) @(negedge clk);
    pulse(2);
    repeat (CV + 8) @(negedge clk);
    chk("R8 busy length unchanged", busyCnt, CV);
    chk("R8 single start", startCnt, 1);
    chk("R8 single result", validCnt + invalidCnt, 1);
    chk("R8 powerUp off", powerUp, 0);
  endtask

  task automatic tStrayDone();
    clrCounts();
    autoDone = 1'b0;
    manualDone = 1'b1;
    pulse(PW + 2);
    manualDone = 1'b0;
    repeat (3 + CV + 3) @(negedge clk);
    chk("R9 stray done ignored", busy, 1);
    chk("R9 no early result", validCnt, 0);
    manualDone = 1'b1;
    @(negedge clk);
    manualDone = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 completes on real done", validCnt, 1);
    autoDone = 1'b1;
  endtask

  task automatic tLongPulse();
    int v, iv;
    runAndCount(37, v, iv);
    chk("R10 long pulse valid", v, 1);
    chk("R10 long pulse no invalid", iv, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tNominal();
    tBoundary();
    tLateDone();
    tRefire();
    tStrayDone();
    tLongPulse();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule